// File: doc/BRIEF.md
# Packet transmit framer

The block receives framed packets from a user packet source on a 64-bit word bus and places each whole packet into one of a fixed pool of packet buffers. Framing uses active-low start-of-frame and end-of-frame markers. The last word carries a remainder code that says whether all 64 bits are valid or only the upper half. A per-packet poison flag marks a packet as corrupted, and a source-side discontinue abandons the packet in progress. When the link enters reset, the block aborts any open packet itself and pulses a destination-side discontinue.

A word moves only on a cycle where both the source and the destination ready signals are low. The sender sees how many whole packet buffers are free. Committed packets appear in commit order on a drain port. The drain side reads the words of the head packet by index, sees the packet's length, half-word flag and poison bit, and releases the buffer with a one-cycle pulse. Packets that are aborted, broken by a protocol error or too long are never committed, and their buffer is reused.

Top module: `pkt_tx_framer`

## Requirements
- R1: A word is taken only on a rising edge where `src_rdy_ni` and `dst_rdy_no` are both low. `dst_rdy_no` is high whenever `buf_av_o` is 0 or `link_rst_ni` is low. While it is high, the stored packets and the free count do not change.
- R2: A packet accepted from a start-of-frame beat to an end-of-frame beat is committed. `drn_len_o` gives its beat count, and `drn_data_o` returns its words in arrival order at indices 0 to length-1. Packets reach the drain port in the order they were committed.
- R3: An end-of-frame remainder code of 8'h0F makes `drn_half_o` 1, meaning only bits [63:32] of the last word are valid. Any other code, including 8'h00 (all bits valid), makes it 0. The code on beats that are not end-of-frame is ignored.
- R4: If `poison_ni` is low on any accepted beat from start-of-frame to end-of-frame inclusive, `drn_poison_o` is 1 for that packet. Otherwise it is 0.
- R5: A cycle with `src_dsc_ni` low closes any open packet without committing it. No beat is stored on that cycle, `buf_av_o` is unchanged, and the next packet reuses the buffer.
- R6: If `link_rst_ni` is sampled low while a packet is open, the packet is dropped. `dst_dsc_no` is then low for exactly the following cycle. When no packet is open, `dst_dsc_no` stays high.
- R7: A start-of-frame beat that arrives while a packet is open drops the open packet, including its poison, and starts a new packet with that beat.
- R8: `buf_av_o` drops by one in the cycle after a commit. It rises by one in the cycle after `drn_rel_i` is high while `drn_vld_o` is 1. It is unchanged when both happen on the same edge. A release with no packet stored is ignored.
- R9: After an end-of-frame, `dst_rdy_no` stays low if a buffer is still free, so the next start-of-frame is accepted on the very next cycle.
- R10: A packet longer than BUF_WORDS beats is dropped, and its remaining beats up to end-of-frame are discarded. A packet of exactly BUF_WORDS beats is committed. Beats that arrive with no packet open and no start-of-frame are ignored.
- R11: After reset, `buf_av_o` equals NUM_BUF, `drn_vld_o` is 0, `dst_dsc_no` is 1 and `dst_rdy_no` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_rdy_ni | input | 1 | Source has a beat, active low |
| dst_rdy_no | output | 1 | Block can take a beat, active low |
| sof_ni | input | 1 | Start-of-frame marker, active low |
| eof_ni | input | 1 | End-of-frame marker, active low |
| data_i | input | 64 | Beat data |
| rem_i | input | 8 | Last-word remainder code |
| poison_ni | input | 1 | Poison the packet, active low |
| src_dsc_ni | input | 1 | Source abandons packet, active low |
| dst_dsc_no | output | 1 | Block aborted packet, active low |
| link_rst_ni | input | 1 | Link entering reset, active low |
| buf_av_o | output | 6 | Free packet buffers |
| drn_vld_o | output | 1 | A committed packet is at the drain head |
| drn_len_o | output | clog2(BUF_WORDS+1) | Head packet length in beats |
| drn_half_o | output | 1 | Head packet's last word has only its upper half valid |
| drn_poison_o | output | 1 | Head packet is poisoned |
| drn_addr_i | input | clog2(BUF_WORDS) | Word index into the head packet |
| drn_data_o | output | 64 | Head packet word at drn_addr_i |
| drn_rel_i | input | 1 | Release the head buffer |

## Verification
A commit from an end-of-frame beat and a buffer release from the drain side can land on the same clock edge. The bench provokes this by driving the final beat of a second packet while it pulses the release of the first. It then requires the free count to be unchanged in the next cycle, and the drain head to show the second packet's length and words. Commit-only and release-only edges are checked separately, so a wrong count step in either direction shows up.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned REM_W   = 8;
  localparam int unsigned MAX_BUF = 32;
  localparam int unsigned FREE_W  = $clog2(MAX_BUF + 1);

  localparam logic [REM_W-1:0] REM_UPPER_HALF = 8'h0F;

  typedef enum logic [1:0] {
    ING_IDLE,
    ING_OPEN,
    ING_DROP
  } ing_state_e;
endpackage

// File: rtl/pkt_tx_ingress.sv
module pkt_tx_ingress
  import pkt_tx_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 64,
  localparam int unsigned LEN_W  = $clog2(BUF_WORDS + 1),
  localparam int unsigned WORD_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_rdy_ni,
  input  logic              sof_ni,
  input  logic              eof_ni,
  input  logic              poison_ni,
  input  logic              src_dsc_ni,
  input  logic              link_rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [REM_W-1:0]  rem_i,
  input  logic [FREE_W-1:0] free_i,
  output logic              dst_rdy_no,
  output logic              dst_dsc_no,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_word_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o,
  output logic [LEN_W-1:0]  commit_len_o,
  output logic              commit_half_o,
  output logic              commit_poison_o
);
  localparam logic [LEN_W-1:0] FULL_CNT = LEN_W'(BUF_WORDS);

  ing_state_e       state_q, state_d;
  logic [LEN_W-1:0] wcnt_q, wcnt_d;
  logic             psn_q, psn_d;
  logic             dsc_q, dsc_d;
  logic             rdy, xfer, sof, eof, poison, src_dsc, link_rst;

  assign link_rst = !link_rst_ni;
  assign sof      = !sof_ni;
  assign eof      = !eof_ni;
  assign poison   = !poison_ni;
  assign src_dsc  = !src_dsc_ni;
  assign rdy      = !link_rst && (free_i != '0);
  assign xfer     = rdy && !src_rdy_ni;

  always_comb begin
    state_d      = state_q;
    wcnt_d       = wcnt_q;
    psn_d        = psn_q;
    dsc_d        = 1'b0;
    wr_en_o      = 1'b0;
    wr_word_o    = '0;
    commit_o     = 1'b0;
    commit_len_o = '0;
    if (link_rst) begin
      if (state_q != ING_IDLE) dsc_d = 1'b1;
      state_d = ING_IDLE;
    end else if (src_dsc) begin
      state_d = ING_IDLE;
    end else if (xfer) begin
      if (sof) begin
        // a fresh start always wins; any open packet is dropped
        wr_en_o = 1'b1;
        wcnt_d  = LEN_W'(1);
        psn_d   = poison;
        if (eof) begin
          commit_o     = 1'b1;
          commit_len_o = LEN_W'(1);
          state_d      = ING_IDLE;
        end else begin
          state_d = ING_OPEN;
        end
      end else if (state_q == ING_OPEN) begin
        if (wcnt_q == FULL_CNT) begin
          state_d = eof ? ING_IDLE : ING_DROP;
        end else begin
          wr_en_o   = 1'b1;
          wr_word_o = wcnt_q[WORD_W-1:0];
          wcnt_d    = wcnt_q + 1'b1;
          psn_d     = psn_q | poison;
          if (eof) begin
            commit_o     = 1'b1;
            commit_len_o = wcnt_q + 1'b1;
            state_d      = ING_IDLE;
          end
        end
      end else if (state_q == ING_DROP && eof) begin
        state_d = ING_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ING_IDLE;
      wcnt_q  <= '0;
      psn_q   <= 1'b0;
      dsc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      psn_q   <= psn_d;
      dsc_q   <= dsc_d;
    end
  end

  assign wr_data_o       = data_i;
  assign commit_half_o   = (rem_i == REM_UPPER_HALF);
  assign commit_poison_o = psn_d;
  assign dst_rdy_no      = !rdy;
  assign dst_dsc_no      = !dsc_q;

  a_r6_dsc_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dst_dsc_no |=> dst_dsc_no);

  a_r1_no_write_without_handshake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_rdy_ni || dst_rdy_no) |-> !wr_en_o);

  a_r5_no_commit_on_discontinue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_dsc_ni |-> !commit_o);

  a_r6_no_write_in_link_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_rst_ni |-> !wr_en_o && !commit_o);
endmodule

// File: rtl/pkt_tx_bufpool.sv
module pkt_tx_bufpool
  import pkt_tx_pkg::*;
#(
  parameter int unsigned NUM_BUF   = 4,
  parameter int unsigned BUF_WORDS = 64,
  localparam int unsigned LEN_W  = $clog2(BUF_WORDS + 1),
  localparam int unsigned WORD_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic [LEN_W-1:0]  commit_len_i,
  input  logic              commit_half_i,
  input  logic              commit_poison_i,
  input  logic              rel_i,
  output logic [FREE_W-1:0] free_o,
  output logic              drn_vld_o,
  output logic [LEN_W-1:0]  drn_len_o,
  output logic              drn_half_o,
  output logic              drn_poison_o,
  input  logic [WORD_W-1:0] drn_addr_i,
  output logic [DATA_W-1:0] drn_data_o
);
  localparam int unsigned BUF_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam int unsigned DEPTH  = NUM_BUF * BUF_WORDS;
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned DESC_W = LEN_W + 2;
  localparam logic [BUF_W-1:0] LAST_BUF = BUF_W'(NUM_BUF - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [BUF_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [FREE_W-1:0] used_q;
  logic [DESC_W-1:0] desc_a [NUM_BUF];
  logic [DESC_W-1:0] head;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              rel_ok;

  assign rel_ok  = rel_i && (used_q != '0);
  assign wr_addr = ADDR_W'(wr_ptr_q) * ADDR_W'(BUF_WORDS) + ADDR_W'(wr_word_i);
  assign rd_addr = ADDR_W'(rd_ptr_q) * ADDR_W'(BUF_WORDS) + ADDR_W'(drn_addr_i);

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr] <= wr_data_i;
  end

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_desc
    logic [DESC_W-1:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                d_q <= '0;
      else if (commit_i && wr_ptr_q == BUF_W'(b)) d_q <= {commit_len_i, commit_half_i, commit_poison_i};
    end
    assign desc_a[b] = d_q;
  end

  // ring order: aborted packets never advance wr_ptr_q, so their buffer is reused
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      used_q   <= '0;
    end else begin
      if (commit_i) wr_ptr_q <= (wr_ptr_q == LAST_BUF) ? '0 : wr_ptr_q + 1'b1;
      if (rel_ok)   rd_ptr_q <= (rd_ptr_q == LAST_BUF) ? '0 : rd_ptr_q + 1'b1;
      if (commit_i && !rel_ok)      used_q <= used_q + 1'b1;
      else if (!commit_i && rel_ok) used_q <= used_q - 1'b1;
    end
  end

  assign head         = desc_a[rd_ptr_q];
  assign free_o       = FREE_W'(NUM_BUF) - used_q;
  assign drn_vld_o    = (used_q != '0);
  assign drn_len_o    = head[DESC_W-1:2];
  assign drn_half_o   = head[1];
  assign drn_poison_o = head[0];
  assign drn_data_o   = mem[rd_addr];

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> used_q < FREE_W'(NUM_BUF));

  a_r8_commit_and_release_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && rel_ok |=> $stable(free_o));

  a_r8_commit_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !rel_ok |=> free_o == $past(free_o) - FREE_W'(1));

  a_r8_release_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i && rel_ok |=> free_o == $past(free_o) + FREE_W'(1));

  a_r10_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> 32'(wr_word_i) < BUF_WORDS);
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
  import pkt_tx_pkg::*;
#(
  parameter int unsigned NUM_BUF   = 4,
  parameter int unsigned BUF_WORDS = 64,
  localparam int unsigned LEN_W  = $clog2(BUF_WORDS + 1),
  localparam int unsigned WORD_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_rdy_ni,
  output logic              dst_rdy_no,
  input  logic              sof_ni,
  input  logic              eof_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [REM_W-1:0]  rem_i,
  input  logic              poison_ni,
  input  logic              src_dsc_ni,
  output logic              dst_dsc_no,
  input  logic              link_rst_ni,
  output logic [FREE_W-1:0] buf_av_o,
  output logic              drn_vld_o,
  output logic [LEN_W-1:0]  drn_len_o,
  output logic              drn_half_o,
  output logic              drn_poison_o,
  input  logic [WORD_W-1:0] drn_addr_i,
  output logic [DATA_W-1:0] drn_data_o,
  input  logic              drn_rel_i
);
  logic              wr_en, commit, commit_half, commit_poison;
  logic [WORD_W-1:0] wr_word;
  logic [DATA_W-1:0] wr_data;
  logic [LEN_W-1:0]  commit_len;

  pkt_tx_ingress #(.BUF_WORDS(BUF_WORDS)) u_ingress (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .src_rdy_ni      (src_rdy_ni),
    .sof_ni          (sof_ni),
    .eof_ni          (eof_ni),
    .poison_ni       (poison_ni),
    .src_dsc_ni      (src_dsc_ni),
    .link_rst_ni     (link_rst_ni),
    .data_i          (data_i),
    .rem_i           (rem_i),
    .free_i          (buf_av_o),
    .dst_rdy_no      (dst_rdy_no),
    .dst_dsc_no      (dst_dsc_no),
    .wr_en_o         (wr_en),
    .wr_word_o       (wr_word),
    .wr_data_o       (wr_data),
    .commit_o        (commit),
    .commit_len_o    (commit_len),
    .commit_half_o   (commit_half),
    .commit_poison_o (commit_poison)
  );

  pkt_tx_bufpool #(.NUM_BUF(NUM_BUF), .BUF_WORDS(BUF_WORDS)) u_pool (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_en_i         (wr_en),
    .wr_word_i       (wr_word),
    .wr_data_i       (wr_data),
    .commit_i        (commit),
    .commit_len_i    (commit_len),
    .commit_half_i   (commit_half),
    .commit_poison_i (commit_poison),
    .rel_i           (drn_rel_i),
    .free_o          (buf_av_o),
    .drn_vld_o       (drn_vld_o),
    .drn_len_o       (drn_len_o),
    .drn_half_o      (drn_half_o),
    .drn_poison_o    (drn_poison_o),
    .drn_addr_i      (drn_addr_i),
    .drn_data_o      (drn_data_o)
  );
endmodule

// File: tb/pkt_tx_framer_test.sv
module pkt_tx_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int LW = $clog2(BW + 1);
  localparam int WW = $clog2(BW);

  logic          clk = 1'b0;
  logic          rst_ni, src_rdy_ni, sof_ni, eof_ni, poison_ni, src_dsc_ni, link_rst_ni, drn_rel_i;
  logic [63:0]   data_i;
  logic [7:0]    rem_i;
  logic [WW-1:0] drn_addr_i;
  logic          dst_rdy_no, dst_dsc_no, drn_vld_o, drn_half_o, drn_poison_o;
  logic [5:0]    buf_av_o;
  logic [LW-1:0] drn_len_o;
  logic [63:0]   drn_data_o;

  int vectors = 0;
  int miscompares = 0;

  int          q_len[$];
  bit          q_half[$];
  bit          q_psn[$];
  logic [63:0] q_word[$];
  logic [63:0] pw [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_tx_framer #(.NUM_BUF(NB), .BUF_WORDS(BW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .src_rdy_ni(src_rdy_ni), .dst_rdy_no(dst_rdy_no),
    .sof_ni(sof_ni), .eof_ni(eof_ni), .data_i(data_i), .rem_i(rem_i),
    .poison_ni(poison_ni), .src_dsc_ni(src_dsc_ni), .dst_dsc_no(dst_dsc_no),
    .link_rst_ni(link_rst_ni), .buf_av_o(buf_av_o), .drn_vld_o(drn_vld_o),
    .drn_len_o(drn_len_o), .drn_half_o(drn_half_o), .drn_poison_o(drn_poison_o),
    .drn_addr_i(drn_addr_i), .drn_data_o(drn_data_o), .drn_rel_i(drn_rel_i)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    src_rdy_ni = 1'b1; sof_ni = 1'b1; eof_ni = 1'b1;
    poison_ni = 1'b1; src_dsc_ni = 1'b1; rem_i = 8'($urandom);
  endtask

  task automatic fill(int len);
    for (int i = 0; i < len; i++) pw[i] = {$urandom, $urandom};
  endtask

  task automatic push_exp(int len, logic [7:0] r, bit p);
    q_len.push_back(len);
    q_half.push_back(r == 8'h0F);
    q_psn.push_back(p);
    for (int i = 0; i < len; i++) q_word.push_back(pw[i]);
  endtask

  // one beat: drive at negedge, wait for ready, transfer at the next posedge
  task automatic beat(bit s, bit e, logic [63:0] d, logic [7:0] r, bit p);
    @(negedge clk);
    src_rdy_ni = 1'b0; sof_ni = !s; eof_ni = !e; data_i = d; rem_i = r; poison_ni = !p;
    src_dsc_ni = 1'b1;
    #1;
    while (dst_rdy_no) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic send_pkt(int len, logic [7:0] r, logic [7:0] rmid, int pbeat,
                          bit expect_commit, bit gaps, bit end_idle);
    for (int i = 0; i < len; i++) begin
      if (gaps && i > 0 && ($urandom % 3) == 0) begin
        @(negedge clk); drive_idle(); @(posedge clk);
      end
      beat(i == 0, i == len - 1, pw[i], (i == len - 1) ? r : rmid, i == pbeat);
    end
    if (expect_commit) push_exp(len, r, pbeat >= 0);
    if (end_idle) begin @(negedge clk); drive_idle(); end
  endtask

  task automatic drain_one(string req, bit rel);
    int l;
    @(negedge clk);
    chk({req, " drain valid"}, drn_vld_o, 1);
    if (q_len.size() == 0) return;
    l = q_len.pop_front();
    chk({req, " length"}, drn_len_o, l);
    chk({req, " half flag"}, drn_half_o, q_half.pop_front());
    chk({req, " poison"}, drn_poison_o, q_psn.pop_front());
    for (int i = 0; i < l; i++) begin
      @(negedge clk);
      drn_addr_i = WW'(i);
      #1;
      chk({req, " word"}, drn_data_o, q_word.pop_front());
    end
    if (rel) begin
      drn_rel_i = 1'b1;
      @(negedge clk);
      drn_rel_i = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++; vectors++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_ni = 1'b0; link_rst_ni = 1'b1; drn_rel_i = 1'b0; drn_addr_i = '0; data_i = '0;
    drive_idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1; #1;
    // R11 reset state
    chk("R11 free count", buf_av_o, NB);
    chk("R11 drain valid", drn_vld_o, 0);
    chk("R11 dst discontinue", dst_dsc_no, 1);
    chk("R11 dst ready", dst_rdy_no, 0);

    // R3/R4 single-beat packet, upper-half code, poisoned
    fill(1);
    send_pkt(1, 8'h0F, 8'h00, 0, 1, 0, 1);
    chk("R8 decrement after commit", buf_av_o, NB - 1);
    drain_one("R3 R4 single beat", 1);
    chk("R8 increment after release", buf_av_o, NB);

    // R3 mid-beat code ignored; R4 poison on a middle beat
    fill(3);
    send_pkt(3, 8'h00, 8'h0F, 1, 1, 0, 1);
    drain_one("R3 mid code ignored", 1);
    // R4 no poison, upper-half code on eof
    fill(2);
    send_pkt(2, 8'h0F, 8'h00, -1, 1, 0, 1);
    drain_one("R4 clean packet", 1);

    // R8 commit and release on the same edge
    fill(2);
    send_pkt(2, 8'h00, 8'h00, -1, 1, 0, 1);
    drain_one("R2 first packet", 0);
    fill(3);
    beat(1, 0, pw[0], 8'h00, 0);
    beat(0, 0, pw[1], 8'h00, 0);
    @(negedge clk);
    sof_ni = 1'b1; eof_ni = 1'b0; data_i = pw[2]; rem_i = 8'h0F; poison_ni = 1'b1;
    src_rdy_ni = 1'b0; drn_rel_i = 1'b1;
    #1 chk("R1 ready with free buffers", dst_rdy_no, 0);
    @(posedge clk);
    @(negedge clk); drn_rel_i = 1'b0; drive_idle();
    push_exp(3, 8'h0F, 0);
    chk("R8 commit and release same edge", buf_av_o, NB - 1);
    drain_one("R2 order after simultaneous", 1);
    @(negedge clk); drn_rel_i = 1'b1;
    @(negedge clk); drn_rel_i = 1'b0;
    chk("R8 release with nothing stored", buf_av_o, NB);
    chk("R8 still empty", drn_vld_o, 0);

    // R5 source discontinue
    fill(3);
    beat(1, 0, pw[0], 8'h00, 0);
    beat(0, 0, pw[1], 8'h00, 0);
    @(negedge clk);
    src_rdy_ni = 1'b0; src_dsc_ni = 1'b0; sof_ni = 1'b1; eof_ni = 1'b0; data_i = pw[2];
    @(posedge clk);
    @(negedge clk); drive_idle();
    chk("R5 no commit on discontinue", buf_av_o, NB);
    chk("R5 nothing to drain", drn_vld_o, 0);
    fill(2);
    send_pkt(2, 8'h00, 8'h00, -1, 1, 0, 1);
    drain_one("R5 packet after discontinue", 1);

    // R6 link reset while open
    fill(2);
    beat(1, 0, pw[0], 8'h00, 0);
    beat(0, 0, pw[1], 8'h00, 0);
    @(negedge clk); drive_idle(); link_rst_ni = 1'b0;
    #1 chk("R6 ready off in link reset", dst_rdy_no, 1);
    chk("R6 no pulse yet", dst_dsc_no, 1);
    @(negedge clk); chk("R6 pulse low", dst_dsc_no, 0);
    @(negedge clk); chk("R6 pulse one cycle", dst_dsc_no, 1);
    link_rst_ni = 1'b1;
    chk("R6 no commit", buf_av_o, NB);
    chk("R6 nothing to drain", drn_vld_o, 0);
    @(negedge clk); link_rst_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R6 idle link reset no pulse", dst_dsc_no, 1);
    link_rst_ni = 1'b1;
    fill(2);
    send_pkt(2, 8'h00, 8'h00, -1, 1, 0, 1);
    drain_one("R6 packet after link reset", 1);

    // R7 start-of-frame while open
    beat(1, 0, 64'hDEAD_0000_0000_0001, 8'h00, 1);
    beat(0, 0, 64'hDEAD_0000_0000_0002, 8'h00, 0);
    fill(2);
    send_pkt(2, 8'h0F, 8'h00, -1, 1, 0, 1);
    chk("R7 one packet stored", buf_av_o, NB - 1);
    drain_one("R7 restarted packet", 1);

    // R10 oversize, stray beats, exact fit
    for (int i = 0; i < BW + 2; i++) beat(i == 0, i == BW + 1, 64'(i), 8'h00, 0);
    @(negedge clk); drive_idle();
    chk("R10 oversize dropped", buf_av_o, NB);
    beat(0, 1, 64'h1234, 8'h00, 0);
    beat(0, 0, 64'h5678, 8'h00, 0);
    @(negedge clk); drive_idle();
    chk("R10 stray beats ignored", buf_av_o, NB);
    chk("R10 nothing to drain", drn_vld_o, 0);
    fill(BW);
    send_pkt(BW, 8'h00, 8'h00, -1, 1, 0, 1);
    drain_one("R10 exact fit", 1);

    // R9 back-to-back until full; R1 hold-off at zero
    for (int k = 0; k < NB; k++) begin
      fill(2);
      send_pkt(2, 8'h00, 8'h00, -1, 1, 0, 0);
      #1;
      if (k < NB - 1) chk("R9 ready stays after eof", dst_rdy_no, 0);
      else            chk("R1 ready off when full", dst_rdy_no, 1);
    end
    @(negedge clk);
    src_rdy_ni = 1'b0; sof_ni = 1'b0; eof_ni = 1'b0; data_i = 64'hBAD;
    @(negedge clk); @(negedge clk);
    chk("R1 nothing taken when full", buf_av_o, 0);
    drive_idle();
    for (int k = 0; k < NB; k++) drain_one("R2 order", 1);
    chk("R8 all free", buf_av_o, NB);

    // random traffic
    for (int n = 0; n < 40; n++) begin
      int len, pb;
      logic [7:0] r;
      if (buf_av_o == 0 || (drn_vld_o && ($urandom % 3) == 0)) drain_one("R2 random", 1);
      len = 1 + int'($urandom % BW);
      pb  = int'($urandom % (len + 1)) - 1;
      case ($urandom % 3)
        0: r = 8'h00;
        1: r = 8'h0F;
        default: r = 8'($urandom);
      endcase
      fill(len);
      send_pkt(len, r, 8'($urandom), pb, 1, 1, 1);
    end
    while (q_len.size() > 0) drain_one("R2 R3 R4 random", 1);
    chk("R8 final free count", buf_av_o, NB);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule